// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits on the write side of a NOR-style flash controller. It watches every bus write cycle, each carrying a 16-bit address and a data byte, and walks a single decode tree that recognises keyed unlock command sequences. When a sequence completes, it raises a one-cycle strobe on the output dedicated to that command. The recognised commands are chip erase, sector erase, program, boot-lockout enable, identification entry and identification exit. Along with the strobe it presents the address and data of the write that completed the command.

Every multi-write command opens with a two-write key: byte AA written to address 5555, then byte 55 written to address 2AAA. A third write to 5555 chooses the branch. Some branches end there. The program branch takes one more write carrying the target location. The erase/lockout branch repeats the key and ends on the sixth write. A lone F0 write at any address, sent while no sequence is open, also leaves identification mode. Any write that breaks the expected pattern closes the sequence without effect. Writes offered while the array controller reports busy are dropped entirely.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, all six strobes are 0, `cmd_addr` is 0 and `cmd_data` is 0. Asserting `rst_n` low in the middle of a sequence discards it, so the next write is decoded as if the block were idle.
- R2: Program: the writes AA@5555, 55@2AAA, A0@5555 and then any address/data raise `stb_program` in the clock cycle after the fourth write is sampled. `cmd_addr`/`cmd_data` equal that fourth write.
- R3: After the two-write key, a third write of 90@5555 raises `stb_id_enter` and F0@5555 raises `stb_id_exit`. Either one ends the sequence. A third write with any other byte, or at an address other than 5555 (except A0 and 80 at 5555), produces no strobe and returns to idle.
- R4: In idle, a single write of F0 to any address raises `stb_id_exit`, with `cmd_addr` set to that address.
- R5: After the key, a third write of 80@5555 opens setup. This must be followed by AA@5555 and 55@2AAA. A sixth write of 10@5555 then raises `stb_chip_erase`, and 40@5555 raises `stb_lock_enable`.
- R6: A sixth write of 30 at any address raises `stb_sector_erase`, with `cmd_addr` equal to the sixth write's address. The strobe appears in the cycle after that write is sampled.
- R7: A write that does not match the expected address and data for the current step returns the block to idle with no strobe. That write is not reinterpreted as the start of a new sequence or as a lone F0 exit.
- R8: A write presented while `array_busy` is 1 is ignored. No strobe results and the sequence position is kept, so the sequence continues with the next write accepted while the array is not busy.
- R9: Each strobe is high for exactly one cycle per completing write, and at most one strobe is high in any cycle. `cmd_addr`/`cmd_data` change only when a strobe is produced.
- R10: In idle, any write other than AA@5555 or data F0 produces no strobe and leaves the block idle.
- R11: Only the 16 address bits and 8 data bits are compared. Command bytes are matched exactly (A0, 90, F0, 80, 10, 30, 40), and the key addresses are matched exactly (5555, 2AAA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A bus write is presented this cycle |
| wr_addr | input | 16 | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| array_busy | input | 1 | Embedded program or erase is running; writes are ignored |
| stb_chip_erase | output | 1 | One-cycle chip erase command |
| stb_sector_erase | output | 1 | One-cycle sector erase command |
| stb_program | output | 1 | One-cycle program command |
| stb_lock_enable | output | 1 | One-cycle boot-lockout enable command |
| stb_id_enter | output | 1 | One-cycle identification entry command |
| stb_id_exit | output | 1 | One-cycle identification exit command |
| cmd_addr | output | 16 | Address of the write that completed the last command |
| cmd_data | output | 8 | Data of the write that completed the last command |

## Verification
The hardest situation to reach from the ports is knowing where the sequence position sits after an abort or a busy-blocked write, because an abort leaves no trace on the outputs. The bench resolves this with a probe write of F0 to a non-key address after each case. That write produces an identification-exit strobe only if the block really is idle; in an open step it aborts silently, and in the program step it yields a program strobe. Every third-step and sixth-step data byte is swept through all 256 values, with the probe following each one. Corruption is then injected at each of the six positions of the long sequence.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_SET1,
    ST_SET2,
    ST_SET3
  } seq_state_t;

  localparam int CMD_N       = 6;
  localparam int CMD_CHIP    = 0;
  localparam int CMD_SECTOR  = 1;
  localparam int CMD_PROG    = 2;
  localparam int CMD_LOCK    = 3;
  localparam int CMD_ID_IN   = 4;
  localparam int CMD_ID_OUT  = 5;

  localparam logic [7:0] OP_KEY_A  = 8'hAA;
  localparam logic [7:0] OP_KEY_B  = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_SETUP  = 8'h80;
  localparam logic [7:0] OP_ID_IN  = 8'h90;
  localparam logic [7:0] OP_ID_OUT = 8'hF0;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECTOR = 8'h30;
  localparam logic [7:0] OP_LOCK   = 8'h40;

  typedef struct packed {
    logic at_key_a;
    logic at_key_b;
    logic is_key_a;
    logic is_key_b;
    logic is_prog;
    logic is_setup;
    logic is_id_in;
    logic is_id_out;
    logic is_chip;
    logic is_sector;
    logic is_lock;
  } key_hits_t;

endpackage

// File: rtl/flash_key_match.sv
module flash_key_match
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output key_hits_t         hits
);

  logic [7:0] op;
  assign op = data[7:0];

  always_comb begin
    hits.at_key_a  = (addr == KEY_ADDR_A);
    hits.at_key_b  = (addr == KEY_ADDR_B);
    hits.is_key_a  = (op == OP_KEY_A);
    hits.is_key_b  = (op == OP_KEY_B);
    hits.is_prog   = (op == OP_PROG);
    hits.is_setup  = (op == OP_SETUP);
    hits.is_id_in  = (op == OP_ID_IN);
    hits.is_id_out = (op == OP_ID_OUT);
    hits.is_chip   = (op == OP_CHIP);
    hits.is_sector = (op == OP_SECTOR);
    hits.is_lock   = (op == OP_LOCK);
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  key_hits_t        hits,
  output logic [CMD_N-1:0] fire
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire    = '0;
    if (accept) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (hits.at_key_a && hits.is_key_a) state_d = ST_UNL1;
          else if (hits.is_id_out)            fire[CMD_ID_OUT] = 1'b1;
        end
        ST_UNL1: if (hits.at_key_b && hits.is_key_b) state_d = ST_UNL2;
        ST_UNL2: begin
          if (hits.at_key_a) begin
            if (hits.is_prog)        state_d = ST_PROG;
            else if (hits.is_setup)  state_d = ST_SET1;
            else if (hits.is_id_in)  fire[CMD_ID_IN]  = 1'b1;
            else if (hits.is_id_out) fire[CMD_ID_OUT] = 1'b1;
          end
        end
        ST_PROG: fire[CMD_PROG] = 1'b1;
        ST_SET1: if (hits.at_key_a && hits.is_key_a) state_d = ST_SET2;
        ST_SET2: if (hits.at_key_b && hits.is_key_b) state_d = ST_SET3;
        ST_SET3: begin
          if (hits.is_sector) fire[CMD_SECTOR] = 1'b1;
          else if (hits.at_key_a) begin
            if (hits.is_chip)      fire[CMD_CHIP] = 1'b1;
            else if (hits.is_lock) fire[CMD_LOCK] = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R2: the write after the program branch always closes the sequence
  p_prog_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_PROG) |=> (state_q == ST_IDLE));

  // R7: a broken key write in the first unlock step never advances
  p_abort_unl1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_UNL1 && !(hits.at_key_b && hits.is_key_b))
      |=> (state_q == ST_IDLE));

  // R8: without an accepted write the position is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(state_q));

endmodule

// File: rtl/flash_cmd_strobe.sv
module flash_cmd_strobe
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_N-1:0]  fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [CMD_N-1:0]  stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic load_en;
  assign load_en = |fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (load_en) begin
      cmd_addr <= addr;
      cmd_data <= data;
    end
  end

  // R9: latched target changes only when a strobe is issued
  p_target_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_addr) |-> (|stb));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              array_busy,
  output logic              stb_chip_erase,
  output logic              stb_sector_erase,
  output logic              stb_program,
  output logic              stb_lock_enable,
  output logic              stb_id_enter,
  output logic              stb_id_exit,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic             accept;
  key_hits_t        hits;
  logic [CMD_N-1:0] fire;
  logic [CMD_N-1:0] stb;

  assign accept = wr_en && !array_busy;

  flash_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .hits(hits)
  );

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hits(hits), .fire(fire)
  );

  flash_cmd_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(wr_addr), .data(wr_data),
    .stb(stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign stb_chip_erase   = stb[CMD_CHIP];
  assign stb_sector_erase = stb[CMD_SECTOR];
  assign stb_program      = stb[CMD_PROG];
  assign stb_lock_enable  = stb[CMD_LOCK];
  assign stb_id_enter     = stb[CMD_ID_IN];
  assign stb_id_exit      = stb[CMD_ID_OUT];

  // R9: never two commands at once
  p_single_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R9: a strobe follows an accepted write on the previous edge
  p_stb_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |-> $past(wr_en && !array_busy));

  // R8: a write blocked by busy yields no command
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy |=> (stb == '0));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int B_CHIP = 0, B_SECT = 1, B_PROG = 2, B_LOCK = 3, B_IDIN = 4, B_IDOUT = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        array_busy;
  logic        s_chip, s_sect, s_prog, s_lock, s_idin, s_idout;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [5:0]  got;

  always #2 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .array_busy(array_busy),
    .stb_chip_erase(s_chip), .stb_sector_erase(s_sect), .stb_program(s_prog),
    .stb_lock_enable(s_lock), .stb_id_enter(s_idin), .stb_id_exit(s_idout),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  function automatic logic [5:0] sv_now();
    return {s_idout, s_idin, s_lock, s_prog, s_sect, s_chip};
  endfunction

  function automatic logic [5:0] one(int b);
    logic [5:0] v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  // one write cycle; afterwards 'got' holds the strobes caused by it
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic busy = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; array_busy = busy;
    @(negedge clk);
    wr_en = 1'b0; array_busy = 1'b0;
    got = sv_now();
  endtask

  task automatic chk_stb(input string req, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s strobes actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic chk_tgt(input string req, input logic [15:0] ea, input logic [7:0] ed);
    checks++;
    if (cmd_addr !== ea || cmd_data !== ed) begin
      errors++;
      $display("FAIL %s target actual=%h/%h expected=%h/%h", req, cmd_addr, cmd_data, ea, ed);
    end
  endtask

  // idle probe: F0 at a non-key address exits ID only if the block is idle
  task automatic probe_idle(input string req);
    wr(16'h1234, 8'hF0);
    chk_stb(req, one(B_IDOUT));
  endtask

  task automatic key(input string req);
    wr(16'h5555, 8'hAA); chk_stb(req, '0);
    wr(16'h2AAA, 8'h55); chk_stb(req, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0]  exp;
    logic [15:0] a6;
    logic [15:0] seq_a [6];
    logic [7:0]  seq_d [6];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; array_busy = 1'b0;
    repeat (3) @(negedge clk);
    got = sv_now();
    chk_stb("R1 in reset", '0);
    chk_tgt("R1 in reset", 16'h0, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    got = sv_now();
    chk_stb("R1 after reset", '0);

    // R3 / R2 / R5 : sweep every third-write byte at the key address
    for (int d = 0; d < 256; d++) begin
      key("R3 key");
      wr(16'h5555, 8'(d));
      exp = (d == 8'h90) ? one(B_IDIN) : (d == 8'hF0) ? one(B_IDOUT) : '0;
      chk_stb("R3 third byte", exp);
      if (d == 8'hA0) begin
        wr(16'h1000 + 16'(d), ~8'(d));
        chk_stb("R2 program", one(B_PROG));
        chk_tgt("R2 program", 16'h1000 + 16'(d), ~8'(d));
      end else if (d == 8'h80) begin
        key("R5 second key");
        wr(16'h5555, 8'h40);
        chk_stb("R5 lockout", one(B_LOCK));
      end
      probe_idle("R3 returns idle");
    end

    // R3: third write at a wrong address
    key("R3 key");
    wr(16'h5554, 8'h90); chk_stb("R3 wrong address", '0);
    probe_idle("R3 wrong address idle");

    // R5 / R6 : sweep the sixth byte at the key address and at a sector address
    for (int s = 0; s < 2; s++) begin
      a6 = (s == 0) ? 16'h5555 : 16'h3F00;
      for (int d = 0; d < 256; d++) begin
        key("R5 key");
        wr(16'h5555, 8'h80); chk_stb("R5 setup", '0);
        key("R5 key2");
        wr(a6, 8'(d));
        if (d == 8'h30)                     exp = one(B_SECT);
        else if (s == 0 && d == 8'h10)      exp = one(B_CHIP);
        else if (s == 0 && d == 8'h40)      exp = one(B_LOCK);
        else                                exp = '0;
        chk_stb("R5/R6 sixth byte", exp);
        if (d == 8'h30) chk_tgt("R6 sector address", a6, 8'h30);
        probe_idle("R7 after sixth byte");
      end
    end

    // R7: corrupt each of the six writes of a chip erase sequence
    for (int k = 0; k < 6; k++) begin
      seq_a = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
      seq_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
      if (k[0]) seq_a[k] = seq_a[k] ^ 16'h0001;
      else      seq_d[k] = seq_d[k] ^ 8'h01;
      for (int i = 0; i < 6; i++) begin
        wr(seq_a[i], seq_d[i]);
        chk_stb("R7 corrupted sequence", '0);
      end
      probe_idle("R7 idle after corruption");
    end

    // R7: mismatching write is not reinterpreted as a new start or as F0 exit
    wr(16'h5555, 8'hAA);
    wr(16'h5555, 8'hAA); chk_stb("R7 restart not taken", '0);
    wr(16'h2AAA, 8'h55); chk_stb("R7 restart not taken", '0);
    wr(16'h5555, 8'hA0); chk_stb("R7 restart not taken", '0);
    wr(16'h0100, 8'h12); chk_stb("R7 no program", '0);
    key("R7 key");
    wr(16'h2AAA, 8'hF0); chk_stb("R7 F0 mid-sequence ignored", '0);
    probe_idle("R7 idle after F0 abort");

    // R4 / R10: single-write behaviour in idle
    wr(16'hBEEF, 8'hF0);
    chk_stb("R4 lone F0", one(B_IDOUT));
    chk_tgt("R4 lone F0 address", 16'hBEEF, 8'hF0);
    for (int d = 0; d < 256; d++) begin
      wr(16'h2AAA, 8'(d));
      chk_stb("R10 idle ignore", (d == 8'hF0) ? one(B_IDOUT) : '0);
    end
    wr(16'h5555, 8'h55); chk_stb("R10 idle ignore", '0);
    probe_idle("R10 still idle");

    // R9: one-cycle strobe and held target
    key("R9 key");
    wr(16'h5555, 8'hA0);
    wr(16'h4321, 8'h5A); chk_stb("R9 program", one(B_PROG));
    @(negedge clk); got = sv_now();
    chk_stb("R9 strobe one cycle", '0);
    wr(16'h0777, 8'h07); chk_stb("R9 ignored write", '0);
    chk_tgt("R9 target held", 16'h4321, 8'h5A);

    // R8: busy writes ignored, position kept
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55, 1'b1); chk_stb("R8 busy write", '0);
    wr(16'h0000, 8'h00, 1'b1); chk_stb("R8 busy write", '0);
    wr(16'h2AAA, 8'h55);       chk_stb("R8 resumed", '0);
    wr(16'h5555, 8'h90);       chk_stb("R8 resumed id enter", one(B_IDIN));
    key("R8 key");
    wr(16'h5555, 8'hA0);
    wr(16'h9999, 8'h99, 1'b1); chk_stb("R8 busy in program step", '0);
    wr(16'h2468, 8'h24);       chk_stb("R8 program after busy", one(B_PROG));
    chk_tgt("R8 program after busy", 16'h2468, 8'h24);
    wr(16'h1111, 8'hF0, 1'b1); chk_stb("R8 busy lone F0", '0);
    chk_tgt("R8 target untouched", 16'h2468, 8'h24);

    // R1: reset mid-sequence
    key("R1 key");
    wr(16'h5555, 8'hA0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); got = sv_now();
    chk_stb("R1 reset mid-sequence", '0);
    chk_tgt("R1 reset clears target", 16'h0, 8'h0);
    rst_n = 1'b1;
    wr(16'h4444, 8'h77); chk_stb("R1 sequence discarded", '0);
    probe_idle("R1 idle after reset");

    // R11: near-miss command bytes and key addresses
    key("R11 key");
    wr(16'h5555, 8'hA1); chk_stb("R11 near-miss byte", '0);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAB, 8'h55); chk_stb("R11 near-miss address", '0);
    probe_idle("R11 idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule